// File: doc/BRIEF.md
# Text Overlay Generator for a Video Raster

This block draws a grid of text characters over a television picture. It tracks the raster from the horizontal and vertical sync inputs and a dot-rate clock, finds which character cell and which dot inside that cell is being scanned, fetches the cell's character code from a small display memory and looks the dot up in an internal glyph table. It drives red, green and blue overlay outputs and a keying output that tells the video path to replace the picture with the overlay.

Colour is chosen per text row and not per character. One selectable row can be split at a programmable column into two colours, which draws a bar gauge such as a volume level. A mode input selects small 5x7 glyphs or large 11x15 glyphs. The dot count of every line is aligned to horizontal sync: counting stops shortly after sync rises and starts again a fixed number of dots after sync falls.

A simple write port (enable, 8-bit address, 8-bit data) loads the display memory and the control registers. Writes are accepted on any cycle.

Top module: `osd_overlay`

## Requirements
- R1: While rst is high and after it is released, all four outputs are 0. At reset every row attribute is 0 (row disabled), the bar-row register reads as no row (7), the split column and both start positions are 0.
- R2: The dot count halts within HALT_DLY (2) clock edges of hsync being sampled high; while it is halted all outputs are 0, even where dot 0 would fall inside the text area.
- R3: Counting the first rising edge at which hsync is sampled low as edge 1, the overlay for dot n of the line (n from 0) is presented just after edge n+RESUME_DLY+2 (RESUME_DLY = 3).
- R4: A vsync pulse makes the line that follows the next hsync line 0; each later hsync pulse advances the line by one.
- R5: The text area holds 6 rows by 20 columns. A cell is 6 dots by 8 lines with small glyphs and 12 dots by 16 lines with large glyphs. Outside the area all outputs are 0.
- R6: Display memory addresses 0 to 119 hold one character code per cell at address row*20+column.
- R7: Code 0x7F lights every dot of the glyph box (columns 0-4 and lines 0-6 of the cell for small glyphs, columns 0-10 and lines 0-14 for large). Code 0x2D lights line 3, columns 0-4 (small) or lines 6-7, columns 0-9 (large). Codes absent from the table, such as 0x00 and 0x41, light nothing.
- R8: The attribute of row r is at address 0x80+r. Bit 7 enables the row (0: the row shows nothing); on a lit dot bits 2:0 give the colour as {red, green, blue} and the key output is 1.
- R9: With attribute bit 3 set, an unlit dot inside an enabled row's cell gives key 1 and colour 000; with it clear such a dot gives all outputs 0.
- R10: Address 0x88 selects the bar row (a value that is not a row number selects none) and 0x89 the split column. In the bar row, lit dots in columns below the split use attribute bits 2:0 and those at or above it use bits 6:4.
- R11: Addresses 0x8A and 0x8B set the first dot and the first line of the text area.
- R12: Input hires = 1 selects large glyphs and cells; hires = 0 selects small ones.
- R13: A colour output is never 1 while the key output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| hires | input | 1 | 1 selects large glyphs |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| ov_r | output | 1 | Red overlay |
| ov_g | output | 1 | Green overlay |
| ov_b | output | 1 | Blue overlay |
| ov_key | output | 1 | Overlay key (replace the picture) |

## Verification
Whole frames are swept dot by dot under three configurations: small glyphs anchored at dot 0 and line 0, large glyphs with an offset origin, and small glyphs with a different offset. The display memory is filled with a mix of full bar cells, dashes, empty codes and codes absent from the table, laid out by different row and column formulas so a wrong address, cell size or line count shows up as a misplaced dot. Each configuration has a disabled row, a background row and a bar row with a split in the middle, at column 0 or elsewhere, which separates per-row colour from the split colour and the background key. The anchored-at-zero frame also shows whether overlay leaks out while the dot count is held at zero during sync.

// File: rtl/osd_pkg.sv
package osd_pkg;

  localparam int LO_GW = 5;
  localparam int LO_GH = 7;
  localparam int HI_GW = 11;
  localparam int HI_GH = 15;
  localparam int LO_CW = 6;
  localparam int LO_CH = 8;
  localparam int HI_CW = 12;
  localparam int HI_CH = 16;

  localparam logic [7:0] CODE_BAR  = 8'h7F;
  localparam logic [7:0] CODE_DASH = 8'h2D;
  localparam logic [7:0] CODE_ZERO = 8'h30;
  localparam logic [7:0] CODE_ONE  = 8'h31;
  localparam logic [7:0] CODE_VEE  = 8'h56;

  // Seven 5-dot rows per glyph, top row in the most significant bits.
  localparam logic [34:0] ROWS_ZERO = {5'b01110, 5'b10001, 5'b10011, 5'b10101,
                                       5'b11001, 5'b10001, 5'b01110};
  localparam logic [34:0] ROWS_ONE  = {5'b00100, 5'b01100, 5'b00100, 5'b00100,
                                       5'b00100, 5'b00100, 5'b01110};
  localparam logic [34:0] ROWS_DASH = {5'b00000, 5'b00000, 5'b00000, 5'b11111,
                                       5'b00000, 5'b00000, 5'b00000};
  localparam logic [34:0] ROWS_VEE  = {5'b10001, 5'b10001, 5'b10001, 5'b10001,
                                       5'b10001, 5'b01010, 5'b00100};

  function automatic logic [4:0] font_row(input logic [7:0] code, input logic [2:0] r);
    logic [34:0] bits;
    case (code)
      CODE_ZERO: bits = ROWS_ZERO;
      CODE_ONE:  bits = ROWS_ONE;
      CODE_DASH: bits = ROWS_DASH;
      CODE_VEE:  bits = ROWS_VEE;
      default:   bits = '0;
    endcase
    if (r > 3'd6) return 5'd0;
    return bits[34 - 5*int'(r) -: 5];
  endfunction

  // Small glyphs use the table directly; large glyphs double it in both
  // directions, except the bar code which fills the full 11x15 box.
  function automatic logic glyph_dot(input logic [7:0] code, input logic [3:0] dx,
                                     input logic [3:0] dy, input logic hires);
    logic [4:0] rowbits;
    if (code == CODE_BAR)
      return hires ? (dx < 4'(HI_GW) && dy < 4'(HI_GH))
                   : (dx < 4'(LO_GW) && dy < 4'(LO_GH));
    if (hires) begin
      if (dx >= 4'd10 || dy >= 4'd14) return 1'b0;
      rowbits = font_row(code, dy[3:1]);
      return rowbits[3'd4 - dx[3:1]];
    end
    if (dx >= 4'(LO_GW) || dy >= 4'(LO_GH)) return 1'b0;
    rowbits = font_row(code, dy[2:0]);
    return rowbits[3'd4 - dx[2:0]];
  endfunction

endpackage

// File: rtl/osd_timing.sv
module osd_timing #(
  parameter int DOT_W      = 10,
  parameter int LINE_W     = 9,
  parameter int HALT_DLY   = 2,
  parameter int RESUME_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync,
  input  logic              vsync,
  output logic              run,
  output logic [DOT_W-1:0]  dot_cnt,
  output logic [LINE_W-1:0] ln_cnt
);
  localparam int DLY_LEN = (HALT_DLY > RESUME_DLY) ? HALT_DLY : RESUME_DLY;

  logic [DLY_LEN-1:0] hs_d;
  logic halt, halt_q, vs_pend;

  always_ff @(posedge clk) begin
    if (rst) hs_d <= '0;
    else     hs_d <= DLY_LEN'({hs_d, hsync});
  end

  assign halt = hs_d[HALT_DLY-1] | hs_d[RESUME_DLY-1];
  assign run  = !halt;

  always_ff @(posedge clk) begin
    if (rst)                dot_cnt <= '0;
    else if (halt)          dot_cnt <= '0;
    else if (dot_cnt != '1) dot_cnt <= dot_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q  <= 1'b0;
      vs_pend <= 1'b0;
      ln_cnt  <= '0;
    end else begin
      halt_q <= halt;
      if (halt && !halt_q) begin
        if (vs_pend)            ln_cnt <= '0;
        else if (ln_cnt != '1)  ln_cnt <= ln_cnt + 1'b1;
        vs_pend <= 1'b0;
      end
      if (vsync) vs_pend <= 1'b1;
    end
  end

  // Checker-side run lengths of the sync input.
  logic [7:0] hi_run, lo_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= hsync ? ((hi_run == 8'hFF) ? hi_run : hi_run + 1'b1) : 8'd0;
      lo_run <= hsync ? 8'd0 : ((lo_run == 8'hFF) ? lo_run : lo_run + 1'b1);
    end
  end

  AST_HALT_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
    (hi_run >= 8'(HALT_DLY)) |-> !run) else $error("dot count not halted"); // R2
  AST_RESUME_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
    (lo_run >= 8'(DLY_LEN)) |-> run) else $error("dot count not resumed"); // R3
  AST_FIRST_LINE_AFTER_VSYNC: assert property (@(posedge clk) disable iff (rst)
    (halt && !halt_q && vs_pend) |=> (ln_cnt == '0)) else $error("line not cleared"); // R4

endmodule

// File: rtl/osd_charmem.sv
module osd_charmem #(
  parameter int CELLS = 120,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr < 8'(CELLS))
      mem[wr_addr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/osd_attr.sv
module osd_attr #(
  parameter int ROWS  = 6,
  parameter int ROW_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [7:0]           wr_addr,
  input  logic [7:0]           wr_data,
  output logic [ROWS-1:0][7:0] row_attr,
  output logic [ROW_W-1:0]     bar_row,
  output logic [7:0]           split_col,
  output logic [7:0]           h_origin,
  output logic [7:0]           v_origin
);
  localparam logic [7:0] ATTR_BASE = 8'h80;
  localparam logic [7:0] A_BAR     = 8'h88;
  localparam logic [7:0] A_SPLIT   = 8'h89;
  localparam logic [7:0] A_HORG    = 8'h8A;
  localparam logic [7:0] A_VORG    = 8'h8B;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)                                     row_attr[i] <= '0;
      else if (wr_en && wr_addr == ATTR_BASE + 8'(i)) row_attr[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bar_row   <= '1;
      split_col <= '0;
      h_origin  <= '0;
      v_origin  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_BAR)   bar_row   <= wr_data[ROW_W-1:0];
      if (wr_addr == A_SPLIT) split_col <= wr_data;
      if (wr_addr == A_HORG)  h_origin  <= wr_data;
      if (wr_addr == A_VORG)  v_origin  <= wr_data;
    end
  end

endmodule

// File: rtl/osd_pixel.sv
module osd_pixel
  import osd_pkg::*;
#(
  parameter int ROWS  = 6,
  parameter int ROW_W = 3,
  parameter int COL_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vis,
  input  logic [ROW_W-1:0]     row,
  input  logic [COL_W-1:0]     col,
  input  logic [3:0]           dx,
  input  logic [3:0]           dy,
  input  logic                 hires,
  input  logic [7:0]           code,
  input  logic [ROWS-1:0][7:0] row_attr,
  input  logic [ROW_W-1:0]     bar_row,
  input  logic [7:0]           split_col,
  output logic                 ov_r,
  output logic                 ov_g,
  output logic                 ov_b,
  output logic                 ov_key
);
  logic [7:0] a;
  logic       lit, show, use_b;
  logic [2:0] fg;

  assign a     = row_attr[row];
  assign lit   = glyph_dot(code, dx, dy, hires);
  assign show  = vis && a[7];
  assign use_b = (row == bar_row) && (8'(col) >= split_col);
  assign fg    = use_b ? a[6:4] : a[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      {ov_r, ov_g, ov_b, ov_key} <= '0;
    end else if (show && lit) begin
      {ov_r, ov_g, ov_b} <= fg;
      ov_key             <= 1'b1;
    end else if (show && a[3]) begin
      {ov_r, ov_g, ov_b} <= 3'b000;
      ov_key             <= 1'b1;
    end else begin
      {ov_r, ov_g, ov_b, ov_key} <= '0;
    end
  end

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !vis |=> !(ov_r | ov_g | ov_b | ov_key)) else $error("overlay outside area"); // R5
  AST_COLOUR_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    (ov_r | ov_g | ov_b) |-> ov_key) else $error("colour without key"); // R13

endmodule

// File: rtl/osd_overlay.sv
module osd_overlay
  import osd_pkg::*;
#(
  parameter int ROWS       = 6,
  parameter int COLS       = 20,
  parameter int DOT_W      = 10,
  parameter int LINE_W     = 9,
  parameter int HALT_DLY   = 2,
  parameter int RESUME_DLY = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       hires,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       ov_r,
  output logic       ov_g,
  output logic       ov_b,
  output logic       ov_key
);
  localparam int CELLS  = ROWS * COLS;
  localparam int MEM_AW = $clog2(CELLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);

  logic              run;
  logic [DOT_W-1:0]  dot_cnt;
  logic [LINE_W-1:0] ln_cnt;
  logic [ROWS-1:0][7:0] row_attr;
  logic [ROW_W-1:0]  bar_row;
  logic [7:0]        split_col, h_origin, v_origin, code;

  osd_timing #(.DOT_W(DOT_W), .LINE_W(LINE_W), .HALT_DLY(HALT_DLY),
               .RESUME_DLY(RESUME_DLY)) i_timing (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
    .run(run), .dot_cnt(dot_cnt), .ln_cnt(ln_cnt));

  osd_attr #(.ROWS(ROWS), .ROW_W(ROW_W)) i_attr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .row_attr(row_attr), .bar_row(bar_row), .split_col(split_col),
    .h_origin(h_origin), .v_origin(v_origin));

  // Stage 0: raster position to cell coordinates.
  logic [DOT_W-1:0]  xs, cw;
  logic [LINE_W-1:0] ys, ch;
  logic              in_h, in_v;
  logic [ROW_W-1:0]  row_s;
  logic [COL_W-1:0]  col_s;
  logic [3:0]        dx_s, dy_s;
  logic [MEM_AW-1:0] raddr;

  assign cw   = hires ? DOT_W'(HI_CW) : DOT_W'(LO_CW);
  assign ch   = hires ? LINE_W'(HI_CH) : LINE_W'(LO_CH);
  assign xs   = dot_cnt - DOT_W'(h_origin);
  assign ys   = ln_cnt - LINE_W'(v_origin);
  assign in_h = run && (dot_cnt >= DOT_W'(h_origin)) && (xs < DOT_W'(COLS) * cw);
  assign in_v = (ln_cnt >= LINE_W'(v_origin)) && (ys < LINE_W'(ROWS) * ch);
  assign col_s = COL_W'(xs / cw);
  assign dx_s  = 4'(xs % cw);
  assign row_s = ROW_W'(ys / ch);
  assign dy_s  = 4'(ys % ch);
  assign raddr = MEM_AW'(row_s) * MEM_AW'(COLS) + MEM_AW'(col_s);

  osd_charmem #(.CELLS(CELLS), .AW(MEM_AW)) i_charmem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(raddr), .rd_data(code));

  // Stage 1: cell coordinates travel beside the memory read.
  logic             vis1, hires1;
  logic [ROW_W-1:0] row1;
  logic [COL_W-1:0] col1;
  logic [3:0]       dx1, dy1;

  always_ff @(posedge clk) begin
    if (rst) begin
      vis1 <= 1'b0; hires1 <= 1'b0;
      row1 <= '0; col1 <= '0; dx1 <= '0; dy1 <= '0;
    end else begin
      vis1 <= in_h && in_v; hires1 <= hires;
      row1 <= row_s; col1 <= col_s; dx1 <= dx_s; dy1 <= dy_s;
    end
  end

  // Stage 2: glyph dot, colour and registered outputs.
  osd_pixel #(.ROWS(ROWS), .ROW_W(ROW_W), .COL_W(COL_W)) i_pixel (
    .clk(clk), .rst(rst), .vis(vis1), .row(row1), .col(col1), .dx(dx1), .dy(dy1),
    .hires(hires1), .code(code), .row_attr(row_attr), .bar_row(bar_row),
    .split_col(split_col), .ov_r(ov_r), .ov_g(ov_g), .ov_b(ov_b), .ov_key(ov_key));

endmodule

// File: tb/test_osd_overlay.sv
`timescale 1ns/1ps
module test_osd_overlay;
  localparam int HALT   = 2;
  localparam int RESUME = 3;
  localparam int HS_W   = 6;

  logic clk = 1'b0, rst = 1'b1, hsync = 1'b0, vsync = 1'b0, hires = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic ov_r, ov_g, ov_b, ov_key;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mem_s [120];
  logic [7:0] attr_s [6];
  int bar_s = 7, split_s = 0, hst = 0, vst = 0;

  osd_overlay i_osd_overlay (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .hires(hires),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ov_r(ov_r), .ov_g(ov_g), .ov_b(ov_b), .ov_key(ov_key));

  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input logic h, input logic v);
    hsync = h; vsync = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [3:0] exp, input string tag, input int ln, input int dot);
    logic [3:0] got;
    got = {ov_r, ov_g, ov_b, ov_key};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s line %0d dot %0d got %b exp %b", tag, ln, dot, got, exp);
    end
  endtask

  // Shadow register decode, taken from R6, R8, R10, R11.
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
    tick(1'b0, 1'b0);
    wr_en = 1'b0;
    if (a < 120) mem_s[a] = 8'(d);
    else if (a >= 'h80 && a < 'h86) attr_s[a - 'h80] = 8'(d);
    else if (a == 'h88) bar_s = d & 7;
    else if (a == 'h89) split_s = d;
    else if (a == 'h8A) hst = d;
    else if (a == 'h8B) vst = d;
  endtask

  function automatic logic [7:0] pick(input int s);
    case (s % 4)
      0: return 8'h7F;
      1: return 8'h2D;
      2: return 8'h00;
      default: return 8'h41;
    endcase
  endfunction

  function automatic logic [3:0] model(input int n, input int ln, output string tag);
    int cw, ch, gw, gh, x, y, col, row, dx, dy;
    logic [7:0] c, a;
    logic lit;
    logic [2:0] fg;
    cw = hires ? 12 : 6;  ch = hires ? 16 : 8;
    gw = hires ? 11 : 5;  gh = hires ? 15 : 7;
    tag = "R5";
    if (n < 0) begin tag = "R3"; return 4'b0; end
    x = n - hst; y = ln - vst;
    if (x < 0 || y < 0 || x >= 20 * cw || y >= 6 * ch) return 4'b0;
    col = x / cw; dx = x % cw; row = y / ch; dy = y % ch;
    c = mem_s[row * 20 + col];
    a = attr_s[row];
    tag = "R8";
    if (!a[7]) return 4'b0;
    if (c == 8'h7F)      lit = (dx < gw) && (dy < gh);
    else if (c == 8'h2D) lit = hires ? ((dy == 6 || dy == 7) && dx < 10) : (dy == 3 && dx < 5);
    else                 lit = 1'b0;
    fg = (row == bar_s && col >= split_s) ? a[6:4] : a[2:0];
    if (lit) begin
      tag = (row == bar_s) ? "R10" : "R7";
      return {fg, 1'b1};
    end
    tag = "R9";
    return a[3] ? 4'b0001 : 4'b0000;
  endfunction

  // R4: line count from vsync; R3: dot alignment after hsync; R11/R12 set per frame.
  task automatic run_frame();
    int cw, ch, nlines, low_len;
    logic [3:0] e;
    string tag;
    cw = hires ? 12 : 6; ch = hires ? 16 : 8;
    nlines  = vst + 6 * ch + 2;
    low_len = RESUME + 1 + hst + 20 * cw + 4;
    tick(1'b0, 1'b1); tick(1'b0, 1'b1); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int ln = 0; ln < nlines; ln++) begin
      for (int k = 0; k < HS_W; k++) begin
        tick(1'b1, 1'b0);
        if (k >= HALT + 1) check(4'b0000, "R2", ln, -1);
      end
      for (int j = 0; j < low_len; j++) begin
        tick(1'b0, 1'b0);
        e = model(j - (RESUME + 1), ln, tag);
        check(e, tag, ln, j - (RESUME + 1));
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) attr_s[i] = 8'h00;
    // R1: outputs quiet in reset and with the reset register values.
    repeat (4) begin
      tick(1'b0, 1'b0);
      check(4'b0000, "R1", -1, -1);
    end
    rst = 1'b0;
    repeat (20) begin
      tick(1'b0, 1'b0);
      check(4'b0000, "R1", -1, -1);
    end

    // Frame A: small glyphs (R12) at origin 0,0 (R11), cells per R6.
    hires = 1'b0;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 20; c++) wr(r * 20 + c, int'(pick(r + c)));
    wr('h80, 'h81); wr('h81, 'h80 | (5 << 4) | 2); wr('h82, 'h88 | 3);
    wr('h83, 'h07); wr('h84, 'h85); wr('h85, 'h86);
    wr('h88, 1); wr('h89, 7); wr('h8A, 0); wr('h8B, 0);
    run_frame();

    // Frame B: large glyphs (R12), offset origin (R11), bar split R10.
    hires = 1'b1;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 20; c++) wr(r * 20 + c, int'(pick(r * 3 + c)));
    wr('h80, 'h87); wr('h81, 'h8B); wr('h82, 'h03); wr('h83, 'h84);
    wr('h84, 'h80 | (6 << 4) | 1); wr('h85, 'h88 | 4);
    wr('h88, 4); wr('h89, 13); wr('h8A, 5); wr('h8B, 3);
    run_frame();

    // Frame C: small glyphs, split at column 0 (whole bar row in second colour).
    hires = 1'b0;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 20; c++) wr(r * 20 + c, int'(pick(c + 2 * r + 1)));
    wr('h80, 'h80 | (3 << 4) | 6); wr('h81, 'h8A); wr('h82, 'h85);
    wr('h83, 'h81); wr('h84, 'h00); wr('h85, 'h82);
    wr('h88, 0); wr('h89, 0); wr('h8A, 9); wr('h8B, 2);
    run_frame();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule